// File: doc/BRIEF.md
# LCD Pixel Formatter with Palette

This block turns a stream of 32-bit frame-buffer words into the signals for an LCD panel. It pulls words from a show-ahead FIFO and cuts them into pixels of 2, 3, 4, 8 or 12 bits. Each pixel becomes a 12-bit colour word. The colour word is then packed onto the lanes of the panel data bus. The block drives that bus together with a shift clock, a line pulse and a frame pulse.

Passive (STN) panels use a 4-lane or 8-lane bus. At 8 bits per pixel, STN pixels are looked up in a 256-entry palette of 12-bit colours, which is loaded through a simple write port. Active (TFT) panels use an 8-lane or 12-lane bus. At 8 bits per pixel, TFT pixels are direct red-green-blue with 3, 3 and 2 bits. At 12 bits per pixel, both panel types use 4 bits for each colour. On request, every lane in use is inverted on odd frames.

The panel size (pixels per row, rows per frame) and the mode are inputs. They are held steady while the block runs and are changed only under reset. After reset the block runs frame after frame without stopping. It stalls only when the FIFO runs dry.

Top module: `lcd_pixel_formatter`

## Requirements
- R1: While `rst_n` is low, `lcd_data`, `lcd_shift_clk`, `lcd_line` and `lcd_frame` are 0. With an empty FIFO, `fifo_pop` is 0.
- R2: `cfg_depth` selects the pixel size: 0 gives 2 bits, 1 gives 3 bits, 2 gives 4 bits, 3 gives 8 bits, 4 gives 12 bits, and 5 to 7 give 2 bits. Pixels are taken from the least significant bit of each word upward. Pixels run on across row ends. Bits left over at the end of a word are joined with the low bits of the next word, so a pixel may span two words.
- R3: At 2, 3 or 4 bits per pixel, the pixel is left-aligned into a 4-bit grey level g (low bits zero). The colour word is then {g,g,g}.
- R4: With `cfg_tft`=0 and 8 bits per pixel, the colour word is the palette entry the pixel indexes. A write with `pal_we` high stores `pal_wdata` at `pal_addr` on that clock edge.
- R5: With `cfg_tft`=1 and 8 bits per pixel, the pixel fields are red [7:5], green [4:2] and blue [1:0]. The colour word is {r,r[2], g,g[2], b,b}.
- R6: At 12 bits per pixel, the colour word is the pixel itself: red [11:8], green [7:4], blue [3:0].
- R7: There are 4 lanes for STN with `cfg_wide`=0, 8 lanes for STN wide and TFT narrow, and 12 lanes for TFT wide. The 4-lane bus carries word[11:8]. The 8-lane bus carries {word[11:9], word[7:5], word[3:2]}. The 12-lane bus carries the whole word. Unused upper lanes are 0.
- R8: Each bus transfer lasts two clocks. `lcd_data`, `lcd_line` and `lcd_frame` change on the first clock, with `lcd_shift_clk` low. `lcd_shift_clk` is high on the second clock and never high on two clocks in a row.
- R9: After the last pixel of each row comes one transfer with `lcd_line`=1 and data 0. `lcd_frame` is 1 only in the line transfer that ends the first row of a frame.
- R10: With `cfg_invert_en`=1, the pixel transfers of odd frames (counted from 0 after reset) have every lane in use inverted. The inversion is applied after the palette or RGB mapping.
- R11: `fifo_pop` is high only while `fifo_empty` is low, and every word popped is used. When no pixel is ready, transfers stall with `lcd_shift_clk` low, and no pixel is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tft | input | 1 | 1 = TFT panel, 0 = STN panel |
| cfg_wide | input | 1 | Selects the wider bus of the panel type |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_invert_en | input | 1 | Invert lanes on odd frames |
| cfg_cols | input | COL_W (10) | Pixels per row, at least 1 |
| cfg_rows | input | ROW_W (10) | Rows per frame, at least 1 |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | WORD_W (32) | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Takes the head word on this edge |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write index |
| pal_wdata | input | 12 | Palette colour to write |
| lcd_data | output | 12 | Panel data lanes |
| lcd_shift_clk | output | 1 | Shift clock, high on the second clock of a transfer |
| lcd_line | output | 1 | Line pulse |
| lcd_frame | output | 1 | Frame pulse |

## Verification
A word popped at clock edge N is in the unpack buffer after that edge. If the sequencer is at the start of a transfer, the pixel it feeds is on `lcd_data` after edge N+1, and `lcd_shift_clk` rises after edge N+2. Line transfers take the two clocks after a row's last pixel transfer. Stalls can stretch any of these gaps, so the bench does not wait a fixed number of cycles. It samples at every falling clock edge and takes the next expected transfer from its reference queue only when the shift clock has just risen. At that point it compares data, line and frame, and also checks that the data was already present one clock earlier. Palette writes take effect on the edge that samples them.

// File: rtl/lcd_fmt_pkg.sv
package lcd_fmt_pkg;
  localparam int PIX_W = 12;

  // depth code -> bits per pixel
  function automatic logic [3:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      3'd4:    return 4'd12;
      default: return 4'd2;
    endcase
  endfunction

  // grey pixel left-aligned to 4 bits, copied to all three colours
  function automatic logic [PIX_W-1:0] grey_word(input logic [3:0] pix, input logic [3:0] nbits);
    logic [3:0] g;
    case (nbits)
      4'd2:    g = {pix[1:0], 2'b00};
      4'd3:    g = {pix[2:0], 1'b0};
      default: g = pix;
    endcase
    return {g, g, g};
  endfunction

  // direct 3-3-2 colour widened to 4-4-4
  function automatic logic [PIX_W-1:0] rgb332_word(input logic [7:0] p);
    return {p[7:5], p[7], p[4:2], p[4], p[1:0], p[1:0]};
  endfunction

  function automatic logic [3:0] lane_count(input logic tft, input logic wide);
    if (tft) return wide ? 4'd12 : 4'd8;
    return wide ? 4'd8 : 4'd4;
  endfunction

  function automatic logic [PIX_W-1:0] lane_pack(input logic [PIX_W-1:0] w, input logic [3:0] lanes);
    case (lanes)
      4'd4:    return {8'b0, w[11:8]};
      4'd8:    return {4'b0, w[11:9], w[7:5], w[3:2]};
      default: return w;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] lane_mask(input logic [3:0] lanes);
    case (lanes)
      4'd4:    return 12'h00F;
      4'd8:    return 12'h0FF;
      default: return 12'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/lcd_palette.sv
module lcd_palette #(
  parameter int ENTRIES = 256,
  parameter int COLOR_W = 12,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [COLOR_W-1:0] rdata
);
  logic [COLOR_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lcd_bit_unpacker.sv
module lcd_bit_unpacker import lcd_fmt_pkg::*; #(
  parameter int WORD_W = 32,
  localparam int BUF_W = 2 * WORD_W,
  localparam int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        nbits,
  input  logic              take,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic [PIX_W-1:0]  pixel,
  output logic              pixel_ok
);
  logic [BUF_W-1:0] bits_q, bits_d, kept;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_left;
  logic [CNT_W-1:0] need;

  assign need     = CNT_W'(nbits);
  assign pixel_ok = cnt_q >= need;
  // refill whenever less than one word is buffered
  assign fifo_pop = !fifo_empty && (cnt_q < CNT_W'(WORD_W));
  assign pixel    = bits_q[PIX_W-1:0] & ((PIX_W'(1) << nbits) - PIX_W'(1));

  always_comb begin
    kept     = take ? (bits_q >> nbits) : bits_q;
    cnt_left = take ? (cnt_q - need) : cnt_q;
    bits_d   = kept;
    cnt_d    = cnt_left;
    if (fifo_pop) begin
      bits_d = kept | ({{(BUF_W - WORD_W){1'b0}}, fifo_data} << cnt_left);
      cnt_d  = cnt_left + CNT_W'(WORD_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(BUF_W));
  assert_take_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pixel_ok);
  assert_pop_refills_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> pixel_ok);
endmodule

// File: rtl/lcd_pixel_map.sv
module lcd_pixel_map import lcd_fmt_pkg::*; #(
  parameter int PAL_AW = 8
) (
  input  logic [PIX_W-1:0]  pixel,
  input  logic [3:0]        nbits,
  input  logic              tft,
  input  logic              wide,
  input  logic              invert,
  input  logic [PIX_W-1:0]  pal_color,
  output logic [PAL_AW-1:0] pal_index,
  output logic [PIX_W-1:0]  bus_val
);
  logic [PIX_W-1:0] color;
  logic [3:0]       lanes;

  assign pal_index = pixel[PAL_AW-1:0];
  assign lanes     = lane_count(tft, wide);

  always_comb begin
    if (nbits == 4'd12)     color = pixel;
    else if (nbits == 4'd8) color = tft ? rgb332_word(pixel[7:0]) : pal_color;
    else                    color = grey_word(pixel[3:0], nbits);
  end

  // inversion follows the colour mapping
  assign bus_val = lane_pack(color, lanes) ^ (invert ? lane_mask(lanes) : '0);
endmodule

// File: rtl/lcd_panel_timing.sv
module lcd_panel_timing import lcd_fmt_pkg::*; #(
  parameter int COL_W = 10,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] cfg_cols,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic             pixel_ok,
  input  logic [PIX_W-1:0] bus_val,
  output logic             take,
  output logic             inv_phase,
  output logic [PIX_W-1:0] lcd_data,
  output logic             lcd_shift_clk,
  output logic             lcd_line,
  output logic             lcd_frame
);
  logic             phase_q, line_pend_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  // named events
  logic slot_line, slot_pixel, col_last, row_last;
  assign slot_line  = !phase_q && line_pend_q;
  assign slot_pixel = !phase_q && !line_pend_q && pixel_ok;
  assign col_last   = (col_q == cfg_cols - COL_W'(1));
  assign row_last   = (row_q == cfg_rows - ROW_W'(1));
  assign take       = slot_pixel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q       <= 1'b0;
      line_pend_q   <= 1'b0;
      col_q         <= '0;
      row_q         <= '0;
      inv_phase     <= 1'b0;
      lcd_data      <= '0;
      lcd_shift_clk <= 1'b0;
      lcd_line      <= 1'b0;
      lcd_frame     <= 1'b0;
    end else if (phase_q) begin
      lcd_shift_clk <= 1'b1;
      phase_q       <= 1'b0;
    end else begin
      lcd_shift_clk <= 1'b0;
      if (slot_line) begin
        lcd_data    <= '0;
        lcd_line    <= 1'b1;
        lcd_frame   <= (row_q == '0);
        line_pend_q <= 1'b0;
        phase_q     <= 1'b1;
        if (row_last) begin
          row_q     <= '0;
          inv_phase <= ~inv_phase;
        end else begin
          row_q <= row_q + ROW_W'(1);
        end
      end else if (slot_pixel) begin
        lcd_data  <= bus_val;
        lcd_line  <= 1'b0;
        lcd_frame <= 1'b0;
        phase_q   <= 1'b1;
        if (col_last) begin
          col_q       <= '0;
          line_pend_q <= 1'b1;
        end else begin
          col_q <= col_q + COL_W'(1);
        end
      end else begin
        lcd_line  <= 1'b0;
        lcd_frame <= 1'b0;
      end
    end
  end

  assert_sclk_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_shift_clk |=> !lcd_shift_clk);
  assert_data_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_shift_clk) |-> ($stable(lcd_data) && $stable(lcd_line)));
  assert_frame_in_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_frame |-> lcd_line);
  assert_line_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_line) |=> (lcd_line && lcd_shift_clk));
endmodule

// File: rtl/lcd_pixel_formatter.sv
module lcd_pixel_formatter import lcd_fmt_pkg::*; #(
  parameter int WORD_W      = 32,
  parameter int COL_W       = 10,
  parameter int ROW_W       = 10,
  parameter int PAL_ENTRIES = 256,
  localparam int PAL_AW     = $clog2(PAL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tft,
  input  logic              cfg_wide,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_invert_en,
  input  logic [COL_W-1:0]  cfg_cols,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic              pal_we,
  input  logic [PAL_AW-1:0] pal_addr,
  input  logic [PIX_W-1:0]  pal_wdata,
  output logic [PIX_W-1:0]  lcd_data,
  output logic              lcd_shift_clk,
  output logic              lcd_line,
  output logic              lcd_frame
);
  logic [3:0]        nbits;
  logic              take, pixel_ok, inv_phase;
  logic [PIX_W-1:0]  pixel, bus_val, pal_color;
  logic [PAL_AW-1:0] pal_index;

  assign nbits = depth_bits(cfg_depth);

  lcd_bit_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .nbits(nbits), .take(take),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .pixel(pixel), .pixel_ok(pixel_ok)
  );

  lcd_palette #(.ENTRIES(PAL_ENTRIES), .COLOR_W(PIX_W)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_addr), .wdata(pal_wdata),
    .raddr(pal_index), .rdata(pal_color)
  );

  lcd_pixel_map #(.PAL_AW(PAL_AW)) u_map (
    .pixel(pixel), .nbits(nbits), .tft(cfg_tft), .wide(cfg_wide),
    .invert(cfg_invert_en && inv_phase), .pal_color(pal_color),
    .pal_index(pal_index), .bus_val(bus_val)
  );

  lcd_panel_timing #(.COL_W(COL_W), .ROW_W(ROW_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
    .pixel_ok(pixel_ok), .bus_val(bus_val), .take(take), .inv_phase(inv_phase),
    .lcd_data(lcd_data), .lcd_shift_clk(lcd_shift_clk),
    .lcd_line(lcd_line), .lcd_frame(lcd_frame)
  );
endmodule

// File: tb/test_lcd_pixel_formatter.sv
`timescale 1ns/1ps
module test_lcd_pixel_formatter;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tft = 1'b0, cfg_wide = 1'b0, cfg_invert_en = 1'b0;
  logic [2:0]  cfg_depth = 3'd0;
  logic [9:0]  cfg_cols = 10'd1, cfg_rows = 10'd1;
  logic        fifo_empty;
  logic [31:0] fifo_data;
  logic        fifo_pop;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = 8'd0;
  logic [11:0] pal_wdata = 12'd0;
  logic [11:0] lcd_data;
  logic        lcd_shift_clk, lcd_line, lcd_frame;

  always #2 clk = ~clk;

  lcd_pixel_formatter i_lcd_pixel_formatter (
    .clk(clk), .rst_n(rst_n), .cfg_tft(cfg_tft), .cfg_wide(cfg_wide),
    .cfg_depth(cfg_depth), .cfg_invert_en(cfg_invert_en),
    .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .lcd_data(lcd_data), .lcd_shift_clk(lcd_shift_clk),
    .lcd_line(lcd_line), .lcd_frame(lcd_frame)
  );

  logic [31:0] word_q[$];
  int exp_data[$], exp_line[$], exp_frame[$];
  int checks = 0, fails = 0, cyc = 0;
  bit feed_on = 0, stall_on = 0, mon_on = 0, popflag = 0, prev_sclk = 0;
  int prev_data = 0;
  string tag = "";

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int pal_color(int a);
    return (a * 37 + 5) % 4096;
  endfunction

  function automatic int model_word(int pix, int bpp, bit tft);
    int r, g, b;
    if (bpp == 12) return pix;
    if (bpp == 8) begin
      if (!tft) return pal_color(pix);
      r = pix >> 5; g = (pix >> 2) & 7; b = pix & 3;
      return ((r * 2 + (r >> 2)) << 8) | ((g * 2 + (g >> 2)) << 4) | (b * 5);
    end
    g = (pix << (4 - bpp)) & 15;
    return g * 273;
  endfunction

  function automatic int model_bus(int w, int lw);
    if (lw == 4) return w >> 8;
    if (lw == 8) return (((w >> 9) & 7) << 5) | (((w >> 5) & 7) << 2) | ((w >> 2) & 3);
    return w;
  endfunction

  // FIFO model: head word shown ahead, popped after the edge that took it
  initial begin
    fifo_empty = 1'b1;
    fifo_data  = '0;
    forever begin
      @(posedge clk);
      #1;
      if (popflag && word_q.size() > 0) void'(word_q.pop_front());
      popflag = 0;
      if (feed_on && !(stall_on && (cyc % 7) < 3) && word_q.size() > 0) begin
        fifo_empty = 1'b0;
        fifo_data  = word_q[0];
      end else begin
        fifo_empty = 1'b1;
        fifo_data  = '0;
      end
    end
  end

  // per-clock monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
      popflag = fifo_pop;
      if (mon_on && fifo_pop && fifo_empty) check("R11", 1, 0, "pop while empty");
      if (mon_on && lcd_shift_clk) begin
        if (prev_sclk) check("R8", 1, 0, "shift clock high twice");
        else begin
          check("R8", int'(lcd_data), prev_data, "data not set up before shift clock");
          if (exp_data.size() == 0) check("R11", 1, 0, "unexpected transfer");
          else begin
            check(tag, int'(lcd_data), exp_data.pop_front(), "data");
            check("R9", int'(lcd_line), exp_line.pop_front(), "line");
            check("R9", int'(lcd_frame), exp_frame.pop_front(), "frame");
          end
        end
      end
      prev_sclk = lcd_shift_clk;
      prev_data = int'(lcd_data);
    end
  end

  task automatic run_case(string t, bit tft, bit wide, int dcode, int bpp,
                          int cols, int rows, int frames, bit inv, bit stall);
    bit bq[$];
    int nwords, lw, mask, n;
    mon_on = 0; feed_on = 0; stall_on = 0;
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_tft = tft; cfg_wide = wide; cfg_depth = 3'(dcode); cfg_invert_en = inv;
    cfg_cols = 10'(cols); cfg_rows = 10'(rows);
    tag = t;
    word_q.delete(); exp_data.delete(); exp_line.delete(); exp_frame.delete();
    nwords = (frames * rows * cols * bpp + 31) / 32;
    for (int i = 0; i < nwords; i++) begin
      logic [31:0] w;
      w = 32'(i + 1) * 32'h9E3779B1 ^ (32'(dcode + 3) << 7);
      word_q.push_back(w);
      for (int k = 0; k < 32; k++) bq.push_back(w[k]);
    end
    lw = tft ? (wide ? 12 : 8) : (wide ? 8 : 4);
    mask = (1 << lw) - 1;
    for (int f = 0; f < frames; f++)
      for (int r = 0; r < rows; r++) begin
        for (int c = 0; c < cols; c++) begin
          int pix, v;
          pix = 0;
          for (int k = 0; k < bpp; k++) pix |= int'(bq.pop_front()) << k;
          v = model_bus(model_word(pix, bpp, tft), lw);
          if (inv && (f % 2 == 1)) v = v ^ mask;
          exp_data.push_back(v); exp_line.push_back(0); exp_frame.push_back(0);
        end
        exp_data.push_back(0); exp_line.push_back(1); exp_frame.push_back(r == 0 ? 1 : 0);
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(lcd_data), 0, "reset data");
    check("R1", int'({lcd_shift_clk, lcd_line, lcd_frame, fifo_pop}), 0, "reset controls");
    @(posedge clk); #1;
    rst_n = 1'b1; mon_on = 1; feed_on = 1; stall_on = stall;
    n = 0;
    while (exp_data.size() > 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) check("R11", exp_data.size(), 0, "transfers missing");
    repeat (40) @(negedge clk);
    check("R11", word_q.size(), 0, "words left unused");
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      @(posedge clk); #1;
      pal_we = 1'b1; pal_addr = 8'(a); pal_wdata = 12'(pal_color(a));
    end
    @(posedge clk); #1;
    pal_we = 1'b0;
    run_case("R3_R7_R10", 0, 0, 0, 2, 8, 2, 2, 1, 0);
    run_case("R2_R3_R11", 0, 1, 1, 3, 16, 2, 1, 0, 1);
    run_case("R3_R7", 0, 0, 2, 4, 8, 1, 2, 0, 0);
    run_case("R4_R10", 0, 1, 3, 8, 4, 2, 2, 1, 0);
    run_case("R5_R7", 1, 0, 3, 8, 4, 2, 1, 0, 0);
    run_case("R5", 1, 1, 3, 8, 4, 1, 1, 0, 0);
    run_case("R6_R2_R10", 1, 1, 4, 12, 8, 2, 2, 1, 1);
    run_case("R6_R7", 1, 0, 4, 12, 8, 1, 1, 0, 0);
    run_case("R2_R3", 0, 0, 6, 2, 16, 1, 1, 0, 0);
    mon_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule